// File: doc/BRIEF.md
# NOR Flash Command Sequencer with Erase Suspend

This block models the write-command front end of a NOR-style flash array on a plain parallel bus. One write strobe cycle carries an address and a data byte. Multi-cycle unlock sequences start a word program, a sector erase, a block erase or a full-array erase. The internal program and erase work is stood in for by cycle counters, and a small register array holds the contents. While an operation runs, reads return a status byte rather than array data. The status byte carries a data-complement polling bit and a bit that alternates on successive reads.

A running sector or block erase can be put on hold with a single-cycle command. The block returns to normal reads after a fixed number of cycles. It remembers the held region and the erase cycles still left. While the erase is held, words outside that region may be programmed, and reads inside it return a distinct status pattern. A single-cycle resume command continues the erase from the stored remaining count. A full-array erase cannot be held, and every write is ignored while it runs.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array word reads 0xFF, `busy` and `suspended` are 0 and `rdata` is 0.
- R2: The sequence AA@555, 55@2AA, A0@555, then data D at address X programs word X. `busy` is 1 for exactly PROG_CYC cycles, starting the cycle after the data write. Afterwards word X reads its old value AND D, so programming only clears bits.
- R3: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA is followed by a sixth write. If that write is 50 at X, it erases the 2^SECT_AW-word sector holding X in SECT_CYC busy cycles. If it is 30 at X, it erases the 2^BLK_AW-word block holding X in BLK_CYC busy cycles. Erased words read 0xFF and other words are unchanged.
- R4: The same prefix ending in 10@555 erases the whole array in CHIP_CYC busy cycles. All writes made while it runs are ignored, including B0 and full program sequences.
- R5: A read has its result on `rdata` in the cycle after `rd_en`. While `busy` is 1, a read returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 6 is a toggle flag that starts at 0 after reset and inverts after every status read. All other bits are 0.
- R6: A write that does not match the next expected cycle of a sequence returns the decoder to idle with no effect. While `busy` is 1, every write other than a qualifying B0 is ignored.
- R7: A write of B0 at any address during a sector or block erase stops the erase count at that edge. `busy` then stays 1 for exactly SUSP_CYC more cycles, after which `suspended` becomes 1.
- R8: While suspended and not busy, a read outside the held region returns array data. A read inside the held region returns 0x40 with bit 2 equal to the toggle flag, and the flag inverts after that read.
- R9: While suspended, a program sequence aimed outside the held region runs normally. One aimed inside the held region starts nothing. All erase sequences are ignored.
- R10: A write of 30 at any address, made while suspended and while the decoder is idle, clears `suspended`. It makes `busy` 1 for exactly the erase cycles that were left, after which the held region reads 0xFF.
- R11: B0 with no sector or block erase running, and 30 with nothing suspended, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One bus write cycle this clock |
| rd_en | input | 1 | One bus read cycle this clock |
| addr | input | ADDR_W | Bus address; the low MEM_AW bits index the array |
| wdata | input | DATA_W | Write data or command byte |
| rdata | output | DATA_W | Registered read result or status byte |
| busy | output | 1 | Program, erase or suspend latency in progress |
| suspended | output | 1 | An erase is held and its region is locked |

## Verification
The hardest state to reach is a held erase with a program running elsewhere, followed by a resume. The erase must then complete in exactly the cycles it still owed. The stimulus starts a sector erase and lets a known number of cycles pass before issuing B0. It then programs a word in another sector and attempts a program and an erase into locked territory before resuming. The bench counts busy cycles at each step. A behavioural model tracks the remaining count and the toggle flag on every clock.

// File: rtl/flash_seq_pkg.sv
// Shared types and command constants for the flash command sequencer.
// Assumes 8-bit command bytes in the low data bits and unlock addresses
// that fit within the bus address width.
package flash_seq_pkg;

    typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_e;
    typedef enum logic [2:0] {CMD_PROG, CMD_SECT, CMD_BLK, CMD_CHIP, CMD_SUSP, CMD_RESUME} cmd_e;

    localparam logic [7:0] K_UNLK1  = 8'hAA;
    localparam logic [7:0] K_UNLK2  = 8'h55;
    localparam logic [7:0] K_PROG   = 8'hA0;
    localparam logic [7:0] K_ERASE  = 8'h80;
    localparam logic [7:0] K_CHIP   = 8'h10;
    localparam logic [7:0] K_SECT   = 8'h50;
    localparam logic [7:0] K_BLK    = 8'h30;
    localparam logic [7:0] K_HOLD   = 8'hB0;
    localparam logic [7:0] K_RESUME = 8'h30;
    localparam int         UNLK_A1  = 'h555;
    localparam int         UNLK_A2  = 'h2AA;

    // True when word indexes a and b fall in the same erase region of the given kind.
    function automatic logic same_region(input op_e kind, input int a, input int b,
                                         input int sect_sh, input int blk_sh);
        int sh;
        sh = (kind == OP_BLK) ? blk_sh : sect_sh;
        return (a >> sh) == (b >> sh);
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
// Write-sequence decoder: walks the unlock steps and emits a one-cycle
// command when a sequence completes. Assumes the controller ignores
// commands it cannot act on; while busy only the hold byte is reported.
module flash_cmd_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic              cmd_vld,
    output cmd_e              cmd
);
    typedef enum logic [2:0] {ST_IDLE, ST_U1, ST_U2, ST_PDAT, ST_E3, ST_E4, ST_E5} step_e;

    step_e      step_q, step_d;
    logic       at_a1, at_a2;
    logic [7:0] kb;

    assign at_a1 = (addr == ADDR_W'(UNLK_A1));
    assign at_a2 = (addr == ADDR_W'(UNLK_A2));
    assign kb    = wdata[7:0];

    // Next step and command pulse from the current step and this write.
    always_comb begin
        step_d  = step_q;
        cmd_vld = 1'b0;
        cmd     = CMD_PROG;
        if (busy) begin
            step_d = ST_IDLE;
            if (wr_en && kb == K_HOLD) begin
                cmd_vld = 1'b1;
                cmd     = CMD_SUSP;
            end
        end else if (wr_en) begin
            step_d = ST_IDLE;
            case (step_q)
                ST_IDLE: if (at_a1 && kb == K_UNLK1) step_d = ST_U1;
                         else if (kb == K_RESUME) begin cmd_vld = 1'b1; cmd = CMD_RESUME; end
                ST_U1:   if (at_a2 && kb == K_UNLK2) step_d = ST_U2;
                ST_U2:   if (at_a1 && kb == K_PROG) step_d = ST_PDAT;
                         else if (at_a1 && kb == K_ERASE) step_d = ST_E3;
                ST_PDAT: begin cmd_vld = 1'b1; cmd = CMD_PROG; end
                ST_E3:   if (at_a1 && kb == K_UNLK1) step_d = ST_E4;
                ST_E4:   if (at_a2 && kb == K_UNLK2) step_d = ST_E5;
                ST_E5:   if (at_a1 && kb == K_CHIP) begin cmd_vld = 1'b1; cmd = CMD_CHIP; end
                         else if (kb == K_SECT) begin cmd_vld = 1'b1; cmd = CMD_SECT; end
                         else if (kb == K_BLK) begin cmd_vld = 1'b1; cmd = CMD_BLK; end
                default: step_d = ST_IDLE;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    AST_DEC_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> step_q == ST_IDLE); // R6

endmodule

// File: rtl/flash_op_ctrl.sv
// Operation controller: runs the program/erase countdown, the hold
// latency and the held-erase bookkeeping (kind, target, cycles left).
// Assumes every *_CYC parameter is at least 2 and SUSP_CYC at least 1.
module flash_op_ctrl
    import flash_seq_pkg::*;
#(
    parameter int MEM_AW   = 6,
    parameter int SECT_AW  = 3,
    parameter int BLK_AW   = 4,
    parameter int DATA_W   = 8,
    parameter int PROG_CYC = 4,
    parameter int SECT_CYC = 16,
    parameter int BLK_CYC  = 24,
    parameter int CHIP_CYC = 40,
    parameter int SUSP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  cmd_e              cmd,
    input  logic [MEM_AW-1:0] tgt_in,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              susp,
    output logic              dq7,
    output op_e               lock_op,
    output logic [MEM_AW-1:0] lock_idx,
    output logic              fin_vld,
    output op_e               fin_op,
    output logic [MEM_AW-1:0] fin_idx,
    output logic [DATA_W-1:0] fin_data
);
    localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_B = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
    localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int SP_W  = $clog2(SUSP_CYC + 1);

    op_e               op_q, sv_op_q;
    logic [CNT_W-1:0]  cnt_q, sv_cnt_q;
    logic [SP_W-1:0]   spc_q;
    logic              pend_q, susp_q;
    logic [MEM_AW-1:0] tgt_q, sv_idx_q;
    logic [DATA_W-1:0] dat_q;
    logic              freeze, lock_hit;

    assign busy     = (op_q != OP_NONE) || pend_q;
    assign susp     = susp_q;
    assign dq7      = (op_q == OP_PROG) ? ~dat_q[7] : 1'b0;
    assign lock_op  = sv_op_q;
    assign lock_idx = sv_idx_q;
    assign freeze   = cmd_vld && cmd == CMD_SUSP && (op_q == OP_SECT || op_q == OP_BLK);
    assign lock_hit = susp_q && same_region(sv_op_q, int'(tgt_in), int'(sv_idx_q), SECT_AW, BLK_AW);
    assign fin_vld  = (op_q != OP_NONE) && cnt_q == CNT_W'(1) && !freeze;
    assign fin_op   = op_q;
    assign fin_idx  = tgt_q;
    assign fin_data = dat_q;

    // Countdown, hold latency, hold/resume and command acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_NONE;  sv_op_q <= OP_NONE;
            cnt_q <= '0;      sv_cnt_q <= '0;   spc_q <= '0;
            pend_q <= 1'b0;   susp_q <= 1'b0;
            tgt_q <= '0;      sv_idx_q <= '0;   dat_q <= '0;
        end else if (freeze) begin
            sv_op_q  <= op_q;
            sv_idx_q <= tgt_q;
            sv_cnt_q <= cnt_q;
            op_q     <= OP_NONE;
            pend_q   <= 1'b1;
            spc_q    <= SP_W'(SUSP_CYC);
        end else if (op_q != OP_NONE) begin
            if (cnt_q == CNT_W'(1)) op_q <= OP_NONE;
            else                    cnt_q <= cnt_q - CNT_W'(1);
        end else if (pend_q) begin
            if (spc_q == SP_W'(1)) begin
                pend_q <= 1'b0;
                susp_q <= 1'b1;
            end else begin
                spc_q <= spc_q - SP_W'(1);
            end
        end else if (cmd_vld) begin
            case (cmd)
                CMD_PROG: if (!lock_hit) begin
                    op_q <= OP_PROG; cnt_q <= CNT_W'(PROG_CYC); tgt_q <= tgt_in; dat_q <= din;
                end
                CMD_SECT: if (!susp_q) begin
                    op_q <= OP_SECT; cnt_q <= CNT_W'(SECT_CYC); tgt_q <= tgt_in;
                end
                CMD_BLK: if (!susp_q) begin
                    op_q <= OP_BLK; cnt_q <= CNT_W'(BLK_CYC); tgt_q <= tgt_in;
                end
                CMD_CHIP: if (!susp_q) begin
                    op_q <= OP_CHIP; cnt_q <= CNT_W'(CHIP_CYC); tgt_q <= tgt_in;
                end
                CMD_RESUME: if (susp_q) begin
                    op_q <= sv_op_q; cnt_q <= sv_cnt_q; tgt_q <= sv_idx_q; susp_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    AST_HOLD_STATES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_q, susp_q})); // R7
    AST_HOLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && spc_q == SP_W'(1) |=> susp_q && !busy); // R7
    AST_CHIP_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        op_q == OP_CHIP |-> !susp_q && !pend_q); // R4
    AST_PROG_OUTSIDE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        op_q == OP_PROG && susp_q |-> !same_region(sv_op_q, int'(tgt_q), int'(sv_idx_q), SECT_AW, BLK_AW)); // R9
    AST_LEFT_CYCLES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        susp_q |=> $stable(sv_cnt_q)); // R10
    AST_RESUME_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_q) |-> cnt_q == $past(sv_cnt_q) && op_q == $past(sv_op_q)); // R10

endmodule

// File: rtl/flash_store.sv
// Array stand-in and read path: applies finished program/erase results
// and returns array data, busy status or the held-region pattern.
// Assumes DATA_W >= 8 so that status bits 7, 6 and 2 exist.
module flash_store
    import flash_seq_pkg::*;
#(
    parameter int MEM_AW  = 6,
    parameter int SECT_AW = 3,
    parameter int BLK_AW  = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] rd_idx,
    input  logic              busy,
    input  logic              susp,
    input  logic              dq7,
    input  op_e               lock_op,
    input  logic [MEM_AW-1:0] lock_idx,
    input  logic              fin_vld,
    input  op_e               fin_op,
    input  logic [MEM_AW-1:0] fin_idx,
    input  logic [DATA_W-1:0] fin_data,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] stat_w, lock_w;
    logic              tgl_q, in_lock;

    assign in_lock = susp && same_region(lock_op, int'(rd_idx), int'(lock_idx), SECT_AW, BLK_AW);

    // Status and held-region read patterns.
    always_comb begin
        stat_w    = '0;
        stat_w[7] = dq7;
        stat_w[6] = tgl_q;
        lock_w    = '0;
        lock_w[6] = 1'b1;
        lock_w[2] = tgl_q;
    end

    // Array update on operation completion.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '1;
            end else if (fin_vld) begin
                case (fin_op)
                    OP_PROG: if (i[MEM_AW-1:0] == fin_idx) mem_q[i] <= mem_q[i] & fin_data;
                    OP_SECT, OP_BLK:
                        if (same_region(fin_op, i, int'(fin_idx), SECT_AW, BLK_AW)) mem_q[i] <= '1;
                    OP_CHIP: mem_q[i] <= '1;
                    default: ;
                endcase
            end
        end
    end

    // Registered read with toggle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tgl_q <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata <= stat_w;
                tgl_q <= ~tgl_q;
            end else if (in_lock) begin
                rdata <= lock_w;
                tgl_q <= ~tgl_q;
            end else begin
                rdata <= mem_q[rd_idx];
            end
        end
    end

    AST_FINISH_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fin_vld |-> busy); // R2
    AST_TOGGLE_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy |=> tgl_q != $past(tgl_q)); // R5

endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer: bus decoder, operation controller
// and array model. Assumes one bus cycle per clock and no simultaneous
// read and write in the same cycle.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int MEM_AW   = 6,
    parameter int SECT_AW  = 3,
    parameter int BLK_AW   = 4,
    parameter int PROG_CYC = 4,
    parameter int SECT_CYC = 16,
    parameter int BLK_CYC  = 24,
    parameter int CHIP_CYC = 40,
    parameter int SUSP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              suspended
);
    logic              cmd_vld, dq7, fin_vld;
    cmd_e              cmd;
    op_e               lock_op, fin_op;
    logic [MEM_AW-1:0] lock_idx, fin_idx;
    logic [DATA_W-1:0] fin_data;

    flash_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .cmd_vld(cmd_vld), .cmd(cmd)
    );

    flash_op_ctrl #(
        .MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW), .DATA_W(DATA_W),
        .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
        .CHIP_CYC(CHIP_CYC), .SUSP_CYC(SUSP_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd),
        .tgt_in(addr[MEM_AW-1:0]), .din(wdata), .busy(busy), .susp(suspended),
        .dq7(dq7), .lock_op(lock_op), .lock_idx(lock_idx), .fin_vld(fin_vld),
        .fin_op(fin_op), .fin_idx(fin_idx), .fin_data(fin_data)
    );

    flash_store #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(addr[MEM_AW-1:0]),
        .busy(busy), .susp(suspended), .dq7(dq7), .lock_op(lock_op),
        .lock_idx(lock_idx), .fin_vld(fin_vld), .fin_op(fin_op),
        .fin_idx(fin_idx), .fin_data(fin_data), .rdata(rdata)
    );

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int PROG_CYC = 4, SECT_CYC = 16, BLK_CYC = 24, CHIP_CYC = 40, SUSP_CYC = 3;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy, suspended;

    int errs = 0, checks = 0;
    bit done = 0;
    string cur = "R1";

    // reference model state
    int m_mem[64];
    int m_op = 0, m_cnt = 0, m_pend = 0, m_susp = 0, m_tgl = 0, m_rdata = 0, m_step = 0;
    int m_tgt = 0, m_dat = 0, m_svop = 0, m_svidx = 0, m_svcnt = 0;

    flash_cmd_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .busy(busy), .suspended(suspended));

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic bit in_reg(input int kind, input int a, input int b);
        int sh = (kind == 3) ? 4 : 3;
        return (a >> sh) == (b >> sh);
    endfunction

    task automatic finish_op();
        for (int j = 0; j < 64; j++) begin
            if (m_op == 1 && j == m_tgt) m_mem[j] = m_mem[j] & m_dat;
            if ((m_op == 2 || m_op == 3) && in_reg(m_op, j, m_tgt)) m_mem[j] = 'hFF;
            if (m_op == 4) m_mem[j] = 'hFF;
        end
        m_op = 0;
    endtask

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int a, d, s;
        bit b;
        a = int'(addr); d = int'(wdata);
        if (!rst_n) begin
            for (int j = 0; j < 64; j++) m_mem[j] = 'hFF;
            m_op = 0; m_cnt = 0; m_pend = 0; m_susp = 0; m_tgl = 0; m_rdata = 0; m_step = 0;
        end else begin
            b = (m_op != 0) || (m_pend > 0);
            if (rd_en) begin
                if (b) begin
                    m_rdata = ((m_op == 1) ? (((m_dat >> 7) & 1) ^ 1) * 128 : 0) + m_tgl * 64;
                    m_tgl ^= 1;
                end else if (m_susp != 0 && in_reg(m_svop, a & 63, m_svidx)) begin
                    m_rdata = 64 + 4 * m_tgl;
                    m_tgl ^= 1;
                end else m_rdata = m_mem[a & 63];
            end
            if (b) begin
                m_step = 0;
                if (wr_en && d == 'hB0 && (m_op == 2 || m_op == 3)) begin
                    m_svop = m_op; m_svidx = m_tgt; m_svcnt = m_cnt; m_op = 0; m_pend = SUSP_CYC;
                end else if (m_op != 0) begin
                    if (m_cnt == 1) finish_op(); else m_cnt--;
                end else begin
                    if (m_pend == 1) m_susp = 1;
                    m_pend--;
                end
            end else if (wr_en) begin
                s = m_step; m_step = 0;
                if (s == 0 && a == 'h555 && d == 'hAA) m_step = 1;
                else if (s == 0 && d == 'h30) begin
                    if (m_susp != 0) begin m_op = m_svop; m_cnt = m_svcnt; m_tgt = m_svidx; m_susp = 0; end
                end
                else if (s == 1 && a == 'h2AA && d == 'h55) m_step = 2;
                else if (s == 2 && a == 'h555 && d == 'hA0) m_step = 3;
                else if (s == 2 && a == 'h555 && d == 'h80) m_step = 4;
                else if (s == 3) begin
                    if (!(m_susp != 0 && in_reg(m_svop, a & 63, m_svidx))) begin
                        m_op = 1; m_cnt = PROG_CYC; m_tgt = a & 63; m_dat = d;
                    end
                end
                else if (s == 4 && a == 'h555 && d == 'hAA) m_step = 5;
                else if (s == 5 && a == 'h2AA && d == 'h55) m_step = 6;
                else if (s == 6 && m_susp == 0) begin
                    if (a == 'h555 && d == 'h10) begin m_op = 4; m_cnt = CHIP_CYC; m_tgt = a & 63; end
                    else if (d == 'h50) begin m_op = 2; m_cnt = SECT_CYC; m_tgt = a & 63; end
                    else if (d == 'h30) begin m_op = 3; m_cnt = BLK_CYC; m_tgt = a & 63; end
                end
            end
        end
    end

    // Compare DUT with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur, " busy"}, int'(busy), ((m_op != 0) || (m_pend > 0)) ? 1 : 0);
            chk({cur, " suspended"}, int'(suspended), m_susp);
            chk({cur, " rdata"}, int'(rdata), m_rdata);
        end
    end

    task automatic cyc(input bit w, input int a, input int d, input bit r);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = 11'(a); wdata = 8'(d);
    endtask
    task automatic wr(input int a, input int d); cyc(1, a, d, 0); endtask
    task automatic idle(); cyc(0, 0, 0, 0); endtask
    task automatic prog(input int a, input int d);
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
    endtask
    task automatic erase(input int a, input int k);
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
        wr('h555, 'hAA); wr('h2AA, 'h55); wr(a, k);
    endtask
    task automatic rd_chk(input string tag, input int a, input int exp);
        cyc(0, a, 0, 1); idle();
        chk(tag, int'(rdata), exp);
    endtask
    task automatic count_busy(output int n);
        n = 0; idle();
        while (busy && n < 1000) begin n++; idle(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog got=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n, r1, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur = "R1";
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 rdata after reset", int'(rdata), 0);
        rd_chk("R1 word 0", 0, 'hFF);
        rd_chk("R1 word 63", 63, 'hFF);
        // R2 / R5: program with status reads
        cur = "R2";
        prog(5, 'h5A);
        cyc(0, 5, 0, 1); cyc(0, 5, 0, 1); r1 = int'(rdata); idle(); r2 = int'(rdata);
        cur = "R5";
        chk("R5 first status", r1, 'h80);
        chk("R5 second status", r2, 'hC0);
        while (busy) idle();
        cur = "R2";
        rd_chk("R2 programmed value", 5, 'h5A);
        prog(5, 'h0F); count_busy(n);
        chk("R2 program busy cycles", n, PROG_CYC);
        rd_chk("R2 bits only cleared", 5, 'h0A);
        // R6: broken sequences
        cur = "R6";
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h77); wr(5, 'h00); idle();
        chk("R6 bad third cycle no busy", int'(busy), 0);
        wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr(5, 'h00); idle();
        rd_chk("R6 word untouched", 5, 'h0A);
        // R11: stray hold / resume
        cur = "R11";
        wr(0, 'hB0); wr(7, 'h30); idle();
        chk("R11 stray commands no busy", int'(busy), 0);
        chk("R11 stray commands no hold", int'(suspended), 0);
        // R3: sector and block erase
        cur = "R3";
        prog(9, 'h33); while (busy || wr_en) idle(); while (busy) idle();
        erase(2, 'h50);
        cyc(0, 2, 0, 1); idle();
        chk("R5 erase status", int'(rdata), 'h00);
        while (busy) idle();
        rd_chk("R3 sector erased", 5, 'hFF);
        rd_chk("R3 next sector kept", 9, 'h33);
        prog('h12, 'h44); while (busy || wr_en) idle(); while (busy) idle();
        prog('h21, 'h66); while (busy || wr_en) idle(); while (busy) idle();
        erase('h17, 'h30); count_busy(n);
        chk("R3 block erase cycles", n, BLK_CYC);
        rd_chk("R3 block erased", 'h12, 'hFF);
        rd_chk("R3 other block kept", 'h21, 'h66);
        rd_chk("R3 low block kept", 9, 'h33);
        // R7..R10: hold, program elsewhere, resume
        cur = "R7";
        erase('h0C, 'h50);
        repeat (5) idle();
        wr(0, 'hB0); count_busy(n);
        chk("R7 hold latency", n, SUSP_CYC);
        chk("R7 suspended flag", int'(suspended), 1);
        cur = "R8";
        rd_chk("R8 outside held sector", 'h21, 'h66);
        cyc(0, 9, 0, 1); cyc(0, 'h0B, 0, 1); r1 = int'(rdata); idle(); r2 = int'(rdata);
        chk("R8 held pattern", r1 & 'hFB, 'h40);
        chk("R8 bit 2 alternates", (r1 ^ r2) & 4, 4);
        cur = "R9";
        prog('h22, 'h55); count_busy(n);
        chk("R9 program outside held sector", n, PROG_CYC);
        rd_chk("R9 outside word written", 'h22, 'h55);
        prog('h0A, 'h00); idle();
        chk("R9 program inside held sector refused", int'(busy), 0);
        erase('h22, 'h50); idle();
        chk("R9 erase while held refused", int'(busy), 0);
        rd_chk("R9 word kept after refused erase", 'h22, 'h55);
        cur = "R11";
        wr(0, 'hB0); idle();
        chk("R11 hold while held no effect", int'(busy), 0);
        cur = "R10";
        wr('h3F, 'h30); count_busy(n);
        chk("R10 remaining cycles", n, SECT_CYC - 5);
        chk("R10 flag cleared", int'(suspended), 0);
        rd_chk("R10 held sector erased", 9, 'hFF);
        rd_chk("R10 outside word kept", 'h22, 'h55);
        // R4: chip erase ignores all writes
        cur = "R4";
        erase('h555, 'h10);
        n = 0; idle();
        while (busy && n < 1000) begin
            n++;
            case (n)
                2: wr(0, 'hB0);
                4: wr('h555, 'hAA);
                5: wr('h2AA, 'h55);
                6: wr('h555, 'hA0);
                7: wr('h22, 'h00);
                default: idle();
            endcase
        end
        chk("R4 chip erase cycles", n, CHIP_CYC);
        rd_chk("R4 word cleared", 'h22, 'hFF);
        rd_chk("R4 word 0 erased", 0, 'hFF);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule